// File: doc/BRIEF.md
# Matrix Coprocessor Data-Movement Controller

This block is the command sequencer and memory addressing of a matrix coprocessor attached to a host microprocessor bus. The host sees two locations, selected by one line: a data location and a command/status location. It writes one-word commands that set the working dimension `n` or the element indices. Other commands move single elements or whole `n`×`n` matrices between the host, two grid-addressed matrix registers (A and C) and a dense main memory that holds matrix B. A and C each cover a 2^m × 2^m grid, and an element's address is the row index concatenated with the column index. Rows and columns at or beyond `n` stay idle. Matrix B is stored packed, row after row, from a base address that comes with the command. It therefore occupies exactly n² consecutive words.

Each command runs on its own after it is accepted. The host polls the status word to see whether the engine is busy, whether a result word is waiting, and whether a command was lost. Internal transfers move one element per clock, with the row index as the outer loop and the column index as the inner loop. Host streams move one element per host access.

Top module: `mcop_mover`

## Requirements
- R1: After reset the status word reads 0 (busy bit 0, data-available bit 1, error bit 2 all clear), and `n` equals 2^m (4 with defaults), so a whole-matrix command then covers 16 elements.
- R2: A write with `sel_i`=1 is a command word: opcode in bits [15:12], argument in bits [11:0]. Opcodes 0, 14 and 15 do nothing. A read with `sel_i`=1 returns the status word. A read with `sel_i`=0 returns the result register. A data write (`sel_i`=0) while no element or stream write is pending is ignored.
- R3: Opcode 1 sets `n` from argument bits [m:0] when the value is 1 to 2^m. Any other value leaves `n` unchanged.
- R4: Opcode 2 sets the row index from argument bits [2m-1:m] and the column index from bits [m-1:0]. Opcode 3 makes the next data write store into A at (row, col). Opcode 4 loads A(row, col) into the result register and sets data-available. If row or col is at least `n`, opcode 3 writes nothing and opcode 4 returns the zero code 16'h4000.
- R5: Opcode 5 accepts the next n² data writes into C at (i, j), with i outer, j inner, each running from 0 to n-1.
- R6: Opcodes 6 (from C) and 7 (from A) present the n×n region one element at a time in the same order. Each element sets data-available, and a data read clears it. The next element appears one cycle later.
- R7: Opcodes 8 (into C) and 9 (into A) copy B, read from address base+i·n+j (base = argument bits [5:0], modulo 64), into element (i, j).
- R8: Opcodes 10 (from C) and 11 (from A) write element (i, j) into B at base+i·n+j.
- R9: Opcode 12 writes the zero code 16'h4000 to every A(i, j) with i, j < n. Opcode 13 writes 16'h0000 (value one) on that region's diagonal and 16'h4000 elsewhere in it.
- R10: No command writes a cell of A or C whose row or column is at least `n`.
- R11: A command written while busy is ignored and sets the error bit. The error bit stays set until a status read clears it, and `n` is unchanged.
- R12: Opcodes 8 to 13 keep the busy bit set for exactly n² cycles, starting with the cycle after the command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, qualifies both strobes |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| sel_i | input | 1 | 1 = command/status location, 0 = data location |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, zero when no read is strobed |

## Verification
The embedded properties watch the following on every cycle:
- the state encoding stays one-hot;
- `n` stays in its legal range and stays fixed while busy;
- no write enable of A or C fires outside the n×n region;
- a busy command raises the error bit;
- a data read drops data-available;
- the walker wraps its column and steps the B address by one;
- an internal walk ends in idle right after its last element.

The values that land in each cell can only be shown by the bench scenarios. These include row-major ordering against the packed B layout, identity and zero patterns, and cells outside the region keeping old data. The scenarios read the full 4×4 grids back through the host streams after each command group and compare them with a reference model.

// File: rtl/mcop_pkg.sv
package mcop_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_SET_N   = 4'd1,
    OP_SET_IDX = 4'd2,
    OP_PUT_A   = 4'd3,
    OP_GET_A   = 4'd4,
    OP_IN_C    = 4'd5,
    OP_OUT_C   = 4'd6,
    OP_OUT_A   = 4'd7,
    OP_LD_C    = 4'd8,
    OP_LD_A    = 4'd9,
    OP_ST_C    = 4'd10,
    OP_ST_A    = 4'd11,
    OP_ZERO_A  = 4'd12,
    OP_IDENT_A = 4'd13,
    OP_RSV14   = 4'd14,
    OP_RSV15   = 4'd15
  } op_e;

  // one-hot state indices
  localparam int S_IDLE = 0;
  localparam int S_PUT  = 1;
  localparam int S_IN   = 2;
  localparam int S_OUT  = 3;
  localparam int S_WALK = 4;
  localparam int S_NUM  = 5;
endpackage

// File: rtl/mcop_ram.sv
module mcop_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mcop_walker.sv
module mcop_walker #(
  parameter int M_LOG   = 2,
  parameter int BADDR_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               step_i,
  input  logic [M_LOG:0]     n_i,
  input  logic [BADDR_W-1:0] base_i,
  output logic [M_LOG-1:0]   row_o,
  output logic [M_LOG-1:0]   col_o,
  output logic [BADDR_W-1:0] baddr_o,
  output logic               last_o
);
  logic [M_LOG:0] nm1;
  logic           col_end;

  assign nm1     = n_i - 1'b1;
  assign col_end = ({1'b0, col_o} == nm1);
  assign last_o  = col_end && ({1'b0, row_o} == nm1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o   <= '0;
      col_o   <= '0;
      baddr_o <= '0;
    end else if (clr_i) begin
      row_o   <= '0;
      col_o   <= '0;
      baddr_o <= base_i;
    end else if (step_i) begin
      if (col_end) begin
        col_o <= '0;
        row_o <= row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
      baddr_o <= baddr_o + 1'b1;
    end
  end

  p_col_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && col_end) |=> (col_o == '0));

  p_baddr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> (baddr_o == $past(baddr_o) + 1'b1));
endmodule

// File: rtl/mcop_mover.sv
module mcop_mover
  import mcop_pkg::*;
#(
  parameter int M_LOG   = 2,
  parameter int DATA_W  = 16,
  parameter int BADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int N_MAX = 1 << M_LOG;
  localparam int GA_W  = 2 * M_LOG;
  localparam int ARG_W = DATA_W - OP_W;
  localparam logic [M_LOG:0]    N_MAX_V   = (M_LOG+1)'(N_MAX);
  localparam logic [DATA_W-1:0] ZERO_CODE = DATA_W'(1) << (DATA_W - 2);
  localparam logic [DATA_W-1:0] ONE_CODE  = '0;

  // host strobes
  logic cmd_wr, dat_wr, stat_rd, dat_rd;
  assign cmd_wr  = cs_i && wr_i && sel_i;
  assign dat_wr  = cs_i && wr_i && !sel_i;
  assign stat_rd = cs_i && rd_i && sel_i;
  assign dat_rd  = cs_i && rd_i && !sel_i;

  // command decode
  op_e              opc;
  logic [ARG_W-1:0] arg;
  logic [M_LOG:0]   n_arg;
  logic             n_ok;
  logic             unused_arg;
  assign opc        = op_e'(wdata_i[DATA_W-1 -: OP_W]);
  assign arg        = wdata_i[ARG_W-1:0];
  assign n_arg      = arg[M_LOG:0];
  assign n_ok       = (n_arg != '0) && (n_arg <= N_MAX_V);
  assign unused_arg = ^arg;

  // state
  logic [S_NUM-1:0] state_q, state_d;
  op_e              op_q, op_d;
  logic [M_LOG:0]   n_q, n_d;
  logic [M_LOG-1:0] row_q, row_d, col_q, col_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic             avail_q, avail_d, err_q, err_d;
  logic             busy;
  assign busy = !state_q[S_IDLE];

  // walker
  logic               walk_clr, walk_step, walk_last;
  logic [M_LOG-1:0]   w_row, w_col;
  logic [BADDR_W-1:0] w_baddr;

  mcop_walker #(.M_LOG(M_LOG), .BADDR_W(BADDR_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (walk_clr),
    .step_i  (walk_step),
    .n_i     (n_q),
    .base_i  (arg[BADDR_W-1:0]),
    .row_o   (w_row),
    .col_o   (w_col),
    .baddr_o (w_baddr),
    .last_o  (walk_last)
  );

  // storage
  logic              a_we, c_we, b_we;
  logic [GA_W-1:0]   a_addr, c_addr;
  logic [DATA_W-1:0] a_wdata, c_wdata, b_wdata;
  logic [DATA_W-1:0] a_rdata, c_rdata, b_rdata;
  logic              idx_in;

  assign idx_in = ({1'b0, row_q} < n_q) && ({1'b0, col_q} < n_q);
  assign a_addr = (state_q[S_IDLE] || state_q[S_PUT]) ? {row_q, col_q} : {w_row, w_col};
  assign c_addr = {w_row, w_col};

  mcop_ram #(.DW(DATA_W), .AW(GA_W)) u_mat_a (
    .clk_i(clk_i), .we_i(a_we), .addr_i(a_addr), .wdata_i(a_wdata), .rdata_o(a_rdata)
  );
  mcop_ram #(.DW(DATA_W), .AW(GA_W)) u_mat_c (
    .clk_i(clk_i), .we_i(c_we), .addr_i(c_addr), .wdata_i(c_wdata), .rdata_o(c_rdata)
  );
  mcop_ram #(.DW(DATA_W), .AW(BADDR_W)) u_mem_b (
    .clk_i(clk_i), .we_i(b_we), .addr_i(w_baddr), .wdata_i(b_wdata), .rdata_o(b_rdata)
  );

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    n_d       = n_q;
    row_d     = row_q;
    col_d     = col_q;
    out_d     = out_q;
    avail_d   = avail_q && !dat_rd;
    err_d     = (cmd_wr && busy) || (err_q && !stat_rd);
    walk_clr  = 1'b0;
    walk_step = 1'b0;
    a_we      = 1'b0;
    c_we      = 1'b0;
    b_we      = 1'b0;
    a_wdata   = wdata_i;
    c_wdata   = wdata_i;
    b_wdata   = c_rdata;

    unique case (1'b1)
      state_q[S_IDLE]: begin
        if (cmd_wr) begin
          unique case (opc)
            OP_SET_N:   if (n_ok) n_d = n_arg;
            OP_SET_IDX: begin
              row_d = arg[GA_W-1:M_LOG];
              col_d = arg[M_LOG-1:0];
            end
            OP_PUT_A:   state_d = S_NUM'(1) << S_PUT;
            OP_GET_A: begin
              out_d   = idx_in ? a_rdata : ZERO_CODE;
              avail_d = 1'b1;
            end
            OP_IN_C: begin
              walk_clr = 1'b1;
              state_d  = S_NUM'(1) << S_IN;
            end
            OP_OUT_C, OP_OUT_A: begin
              walk_clr = 1'b1;
              op_d     = opc;
              avail_d  = 1'b0;
              state_d  = S_NUM'(1) << S_OUT;
            end
            OP_LD_C, OP_LD_A, OP_ST_C, OP_ST_A, OP_ZERO_A, OP_IDENT_A: begin
              walk_clr = 1'b1;
              op_d     = opc;
              state_d  = S_NUM'(1) << S_WALK;
            end
            default: ;
          endcase
        end
      end
      state_q[S_PUT]: begin
        if (dat_wr) begin
          a_we    = idx_in;
          state_d = S_NUM'(1) << S_IDLE;
        end
      end
      state_q[S_IN]: begin
        if (dat_wr) begin
          c_we = 1'b1;
          if (walk_last) state_d = S_NUM'(1) << S_IDLE;
          else           walk_step = 1'b1;
        end
      end
      state_q[S_OUT]: begin
        if (!avail_q) begin
          out_d   = (op_q == OP_OUT_C) ? c_rdata : a_rdata;
          avail_d = 1'b1;
          if (walk_last) state_d = S_NUM'(1) << S_IDLE;
          else           walk_step = 1'b1;
        end
      end
      state_q[S_WALK]: begin
        unique case (op_q)
          OP_LD_C: begin c_we = 1'b1; c_wdata = b_rdata; end
          OP_LD_A: begin a_we = 1'b1; a_wdata = b_rdata; end
          OP_ST_C: begin b_we = 1'b1; b_wdata = c_rdata; end
          OP_ST_A: begin b_we = 1'b1; b_wdata = a_rdata; end
          OP_ZERO_A: begin a_we = 1'b1; a_wdata = ZERO_CODE; end
          OP_IDENT_A: begin
            a_we    = 1'b1;
            a_wdata = (w_row == w_col) ? ONE_CODE : ZERO_CODE;
          end
          default: ;
        endcase
        if (walk_last) state_d = S_NUM'(1) << S_IDLE;
        else           walk_step = 1'b1;
      end
      default: state_d = S_NUM'(1) << S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_NUM'(1) << S_IDLE;
      op_q    <= OP_NOP;
      n_q     <= N_MAX_V;
      row_q   <= '0;
      col_q   <= '0;
      out_q   <= '0;
      avail_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      n_q     <= n_d;
      row_q   <= row_d;
      col_q   <= col_d;
      out_q   <= out_d;
      avail_q <= avail_d;
      err_q   <= err_d;
    end
  end

  logic [DATA_W-1:0] status;
  assign status  = {{(DATA_W-3){1'b0}}, err_q, avail_q, busy};
  assign rdata_o = !(cs_i && rd_i) ? '0 : (sel_i ? status : out_q);

  p_state_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  p_n_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q != '0) && (n_q <= N_MAX_V));

  p_a_inside_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we |-> (({1'b0, a_addr[GA_W-1:M_LOG]} < n_q) && ({1'b0, a_addr[M_LOG-1:0]} < n_q)));

  p_c_inside_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we |-> (({1'b0, c_addr[GA_W-1:M_LOG]} < n_q) && ({1'b0, c_addr[M_LOG-1:0]} < n_q)));

  p_busy_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy) |=> err_q);

  p_n_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(n_q));

  p_pop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd && !wr_i) |=> !avail_q);

  p_walk_exit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q[S_WALK] && walk_last) |=> state_q[S_IDLE]);
endmodule

// File: tb/sim_mcop_mover.sv
module sim_mcop_mover;
  localparam int CLK_P = 10;
  localparam int NM    = 4;
  localparam logic [15:0] ZC = 16'h4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, wr = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0, cur_n = NM;
  logic [15:0] ref_a [16];
  logic [15:0] ref_c [16];
  logic [15:0] ref_b [64];

  always #(CLK_P/2) clk = ~clk;

  mcop_mover u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .sel_i(sel), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [15:0] d);
    cs = 1'b1; wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic s, output logic [15:0] d);
    cs = 1'b1; rd = 1'b1; sel = s;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic cmd(input int op, input int a);
    bus_wr(1'b1, {op[3:0], a[11:0]});
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do bus_rd(1'b1, s); while (s[0]);
  endtask

  task automatic set_n(input int v);
    cmd(1, v);
    if (v >= 1 && v <= NM) cur_n = v;
  endtask

  task automatic timed(input int op, input int a, input string req);
    logic [15:0] s;
    int cnt = 0;
    cmd(op, a);
    do begin
      bus_rd(1'b1, s);
      if (s[0]) cnt++;
    end while (s[0]);
    chk(cnt == cur_n*cur_n, req, 16'(cnt), 16'(cur_n*cur_n));
  endtask

  task automatic stream_out(input int op, input string req);
    logic [15:0] s, d, e;
    cmd(op, 0);
    for (int i = 0; i < cur_n; i++)
      for (int j = 0; j < cur_n; j++) begin
        do bus_rd(1'b1, s); while (!s[1]);
        bus_rd(1'b0, d);
        e = (op == 7) ? ref_a[i*NM+j] : ref_c[i*NM+j];
        chk(d === e, req, d, e);
      end
    wait_idle();
  endtask

  task automatic verify(input string req);
    int keep = cur_n;
    set_n(NM);
    stream_out(7, req);
    stream_out(6, req);
    set_n(keep);
  endtask

  task automatic stream_in(input logic [15:0] seed);
    cmd(5, 0);
    for (int i = 0; i < cur_n; i++)
      for (int j = 0; j < cur_n; j++) begin
        logic [15:0] w = seed + 16'(i*37 + j*5);
        bus_wr(1'b0, w);
        ref_c[i*NM+j] = w;
      end
    wait_idle();
  endtask

  // R1 R12: reset status, default n, walk busy length
  task automatic t_reset();
    logic [15:0] s;
    bus_rd(1'b1, s);
    chk(s == 16'h0000, "R1 status after reset", s, 16'h0000);
    timed(12, 0, "R1 R12 zero at default n");
    for (int k = 0; k < 16; k++) ref_a[k] = ZC;
  endtask

  // R5 R6: full stream in and out
  task automatic t_stream_full();
    stream_in(16'h1100);
    verify("R5 R6 full stream");
  endtask

  // R7 R8 R10: store C, then packed load into A at n=3
  task automatic t_store_load();
    timed(10, 5, "R8 R12 store C busy");
    for (int k = 0; k < 16; k++) ref_b[5+k] = ref_c[k];
    set_n(3);
    timed(9, 5, "R7 R12 load A busy");
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) ref_a[i*NM+j] = ref_b[5+i*3+j];
    verify("R7 R10 packed load");
  endtask

  // R4: element access inside and outside the region
  task automatic t_elem();
    logic [15:0] s, d;
    cmd(2, (1 << 2) | 2);
    cmd(3, 0);
    bus_wr(1'b0, 16'hBEEF);
    ref_a[1*NM+2] = 16'hBEEF;
    cmd(4, 0);
    do bus_rd(1'b1, s); while (!s[1]);
    bus_rd(1'b0, d);
    chk(d == 16'hBEEF, "R4 get in range", d, 16'hBEEF);
    bus_rd(1'b1, s);
    chk(s[1] == 1'b0, "R6 read clears avail", {15'd0, s[1]}, 16'h0000);
    cmd(2, (3 << 2) | 1);
    cmd(3, 0);
    bus_wr(1'b0, 16'h7777);
    cmd(4, 0);
    do bus_rd(1'b1, s); while (!s[1]);
    bus_rd(1'b0, d);
    chk(d == ZC, "R4 get out of range", d, ZC);
    bus_wr(1'b0, 16'h5A5A);  // R2 stray data write, ignored
    verify("R2 R4 R10 after element access");
  endtask

  // R9: identity within a 3x3 region
  task automatic t_ident();
    timed(13, 0, "R9 R12 ident busy");
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) ref_a[i*NM+j] = (i == j) ? 16'h0000 : ZC;
    verify("R9 identity region");
  endtask

  // R5: stream at n=2
  task automatic t_small_in();
    set_n(2);
    stream_in(16'h2200);
    verify("R5 R10 small stream");
  endtask

  // R8 R7: store A, load C at n=2
  task automatic t_store_a();
    timed(11, 40, "R8 store A busy");
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) ref_b[40+i*2+j] = ref_a[i*NM+j];
    timed(8, 40, "R7 load C busy");
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) ref_c[i*NM+j] = ref_b[40+i*2+j];
    verify("R7 R8 A through B into C");
  endtask

  // R3: illegal sizes ignored
  task automatic t_setn();
    set_n(2);
    cmd(1, 0);
    cmd(1, 5);
    cmd(14, 0);  // R2 reserved opcode
    timed(12, 0, "R3 n kept after illegal sizes");
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) ref_a[i*NM+j] = ZC;
    verify("R3 R9 zero region");
  endtask

  // R11: command while busy
  task automatic t_busy();
    logic [15:0] s;
    set_n(4);
    cmd(12, 0);
    cmd(1, 1);
    bus_rd(1'b1, s);
    chk(s[2] && s[0], "R11 error and busy set", s, 16'h0005);
    bus_rd(1'b1, s);
    chk(s[2] == 1'b0, "R11 error cleared by status read", s, 16'h0000);
    wait_idle();
    for (int k = 0; k < 16; k++) ref_a[k] = ZC;
    timed(12, 0, "R11 n unchanged by ignored command");
    verify("R11 R9 final grids");
  endtask

  initial begin
    #(CLK_P*150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream_full();
    t_store_load();
    t_elem();
    t_ident();
    t_small_in();
    t_store_a();
    t_setn();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule